// File: doc/BRIEF.md
# Multi-Line Receive Silo with Character Alarm

This block collects received characters from a small group of serial receivers into one shared first-in first-out store (the silo). A scanner visits the lines in rotation. When the visited line is enabled, reports a character available and the silo has room, the character enters the silo. It is stored with the line number and the parity, framing and overrun flags. The block then sends a one-cycle clear pulse back to that line's data-available flag.

The host reads one entry per read strobe. The entry comes back as a fixed 16-bit receive word with a data-valid bit taken at the moment of the read. A receiver-done output shows that the silo holds at least one entry. An alarm output rises once a set number of characters have entered since the alarm was last cleared. A host read clears the alarm, and so does dropping the alarm enable.

Top module: `rx_silo_ctrl`

## Requirements
- R1: No character is loaded while `scan_en` is 0, and no character is loaded from a line whose `line_rx_en` bit is 0. Such a line keeps its `line_avail` flag set and `avail_clr` stays 0.
- R2: A character is loaded when the scanned line is enabled, its `line_avail` bit is 1 and the silo is not full. In the cycle after the load, `avail_clr` is one-hot on that line for exactly one cycle.
- R3: The receive word has this layout: bit 15 data valid, bit 14 overrun, bit 13 framing error, bit 12 parity error, bits 11:10 zero, bits 9:8 line number, bits 7:0 data.
- R4: `rx_done` is 1 exactly when the silo holds at least one entry.
- R5: A pulse on `rd_strobe` while the silo is non-empty removes the oldest entry. After the clock edge, `rd_word` holds that entry with data valid set, and entries leave in the order they entered.
- R6: A read of an empty silo sets `rd_word` to all zeros, so data valid is 0, and leaves the silo empty.
- R7: The silo holds 64 entries. While it is full, no load happens and the line's `line_avail` stays set. The pending character loads once a read frees a slot.
- R8: While `alarm_en` is 1, `alarm` rises on the clock edge at which the 16th character since the last clear enters the silo, and it stays high until cleared.
- R9: A read strobe, or `alarm_en` at 0, clears `alarm` at the next edge and restarts the character count from zero. A load in the same cycle as a clear is not counted.
- R10: Characters waiting on several lines at once are each loaded once, and each is tagged with its own line number, data and flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scan_en | input | 1 | Master enable for the line scanner |
| line_rx_en | input | 4 | Per-line receive enable |
| line_avail | input | 4 | Per-line character-available flag |
| line_data | input | 32 | Received byte of line k in bits 8k+7:8k |
| line_par_err | input | 4 | Per-line parity error flag |
| line_frm_err | input | 4 | Per-line framing error flag |
| line_ovr_err | input | 4 | Per-line overrun flag |
| alarm_en | input | 1 | Alarm enable; 0 holds the alarm clear |
| rd_strobe | input | 1 | One-cycle host read of the receive word |
| avail_clr | output | 4 | One-cycle pulse that clears a line's available flag |
| rd_word | output | 16 | Receive word captured by the last read |
| rx_done | output | 1 | Silo holds at least one entry |
| alarm | output | 1 | Character-count alarm |

## Verification
The assertions rely on three things about the inputs. Each line drops its `line_avail` flag within a few cycles of its `avail_clr` pulse. The per-line data and flags stay steady while a character waits. `rd_strobe` is a single-cycle pulse. The bench's receiver model drives a line's byte and flags together with its available flag, and clears the flag at the first falling edge that shows the clear pulse. That falls well inside one scan rotation. Reads come from a task that raises the strobe for exactly one cycle.

// File: rtl/rx_silo_pkg.sv
package rx_silo_pkg;

   localparam int WORD_W = 16;
   localparam int BYTE_W = 8;
   localparam int TAG_W  = 2;

   typedef struct packed {
      logic              ovr;
      logic              frm;
      logic              par;
      logic [TAG_W-1:0]  line;
      logic [BYTE_W-1:0] data;
   } silo_entry_t;

   localparam int ENTRY_W = $bits(silo_entry_t);

   function automatic logic [WORD_W-1:0] pack_word(input logic valid,
                                                   input silo_entry_t e);
      pack_word = {valid, e.ovr, e.frm, e.par, 2'b00, e.line, e.data};
   endfunction

endpackage

// File: rtl/rx_line_scanner.sv
module rx_line_scanner #(
   parameter int NUM_LINES = 4,
   parameter int TAG_W     = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 scan_en,
   input  logic [NUM_LINES-1:0] line_rx_en,
   input  logic [NUM_LINES-1:0] line_avail,
   input  logic                 silo_full,
   output logic                 load,
   output logic [TAG_W-1:0]     load_line,
   output logic [NUM_LINES-1:0] avail_clr
);
   localparam int IDX_W = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_LINES - 1);

   logic [IDX_W-1:0] idx;

   generate
      if (NUM_LINES < 2 || NUM_LINES > (1 << TAG_W)) begin : g_bad_lines
         $error("rx_line_scanner: NUM_LINES out of range");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         idx <= '0;
      else if (scan_en)
         idx <= (idx == LAST) ? '0 : idx + 1'b1;
   end

   assign load      = scan_en && line_rx_en[idx] && line_avail[idx] && !silo_full;
   assign load_line = TAG_W'(idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         avail_clr <= '0;
      else if (load)
         avail_clr <= NUM_LINES'(1) << idx;
      else
         avail_clr <= '0;
   end

   // R1: scanning is gated by master enable
   a_r1_no_load_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !scan_en |-> !load);
   // R2: one-hot clear pulse follows each load
   a_r2_clr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> $onehot(avail_clr));
   a_r2_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> avail_clr == '0);
endmodule

// File: rtl/rx_silo_fifo.sv
module rx_silo_fifo #(
   parameter int DEPTH = 64,
   parameter int WIDTH = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic             empty,
   output logic             full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = AW + 1;
   localparam bit POW2 = (DEPTH == (1 << AW));
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0]    count;

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("rx_silo_fifo: DEPTH must be at least 2");
      end
      if (POW2) begin : g_wrap_nat
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   assign empty = (count == '0);
   assign full  = (count == FULL_CNT);
   assign head  = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push)
         mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R7: never written past capacity
   a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= FULL_CNT);
   // R6: never read past empty
   a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/rx_silo_alarm.sv
module rx_silo_alarm #(
   parameter int THRESH = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic alarm_en,
   input  logic load,
   input  logic rd,
   output logic alarm
);
   localparam int CNT_W = $clog2(THRESH + 1);
   localparam logic [CNT_W-1:0] LIM    = CNT_W'(THRESH);
   localparam logic [CNT_W-1:0] LIM_M1 = CNT_W'(THRESH - 1);

   logic [CNT_W-1:0] cnt;

   generate
      if (THRESH < 1) begin : g_bad_thresh
         $error("rx_silo_alarm: THRESH must be positive");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         alarm <= 1'b0;
      end else if (!alarm_en || rd) begin
         cnt   <= '0;
         alarm <= 1'b0;
      end else if (load && cnt != LIM) begin
         cnt <= cnt + 1'b1;
         if (cnt == LIM_M1)
            alarm <= 1'b1;
      end
   end

   // R9: either clear source drops the alarm
   a_r9_clear_rd: assert property (@(posedge clk) disable iff (!rst_n)
      rd |=> !alarm);
   a_r9_clear_en: assert property (@(posedge clk) disable iff (!rst_n)
      !alarm_en |=> !alarm);
   // R8: alarm only rises on a counted load
   a_r8_rise_on_load: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm) |-> $past(load));
endmodule

// File: rtl/rx_silo_ctrl.sv
module rx_silo_ctrl
   import rx_silo_pkg::*;
#(
   parameter int NUM_LINES = 4,
   parameter int DEPTH     = 64,
   parameter int ALARM_CNT = 16
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        scan_en,
   input  logic [NUM_LINES-1:0]        line_rx_en,
   input  logic [NUM_LINES-1:0]        line_avail,
   input  logic [NUM_LINES*BYTE_W-1:0] line_data,
   input  logic [NUM_LINES-1:0]        line_par_err,
   input  logic [NUM_LINES-1:0]        line_frm_err,
   input  logic [NUM_LINES-1:0]        line_ovr_err,
   input  logic                        alarm_en,
   input  logic                        rd_strobe,
   output logic [NUM_LINES-1:0]        avail_clr,
   output logic [WORD_W-1:0]           rd_word,
   output logic                        rx_done,
   output logic                        alarm
);
   logic             load;
   logic [TAG_W-1:0] load_line;
   logic             silo_full, silo_empty, pop;
   silo_entry_t      new_entry, head_entry;

   rx_line_scanner #(.NUM_LINES(NUM_LINES), .TAG_W(TAG_W)) u_scan (
      .clk        (clk),
      .rst_n      (rst_n),
      .scan_en    (scan_en),
      .line_rx_en (line_rx_en),
      .line_avail (line_avail),
      .silo_full  (silo_full),
      .load       (load),
      .load_line  (load_line),
      .avail_clr  (avail_clr)
   );

   always_comb begin
      new_entry      = '0;
      new_entry.line = load_line;
      for (int k = 0; k < NUM_LINES; k++) begin
         if (load_line == TAG_W'(k)) begin
            new_entry.data = line_data[k*BYTE_W +: BYTE_W];
            new_entry.par  = line_par_err[k];
            new_entry.frm  = line_frm_err[k];
            new_entry.ovr  = line_ovr_err[k];
         end
      end
   end

   assign pop = rd_strobe && !silo_empty;

   rx_silo_fifo #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) u_silo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (load),
      .push_data (new_entry),
      .pop       (pop),
      .head      (head_entry),
      .empty     (silo_empty),
      .full      (silo_full)
   );

   assign rx_done = !silo_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_word <= '0;
      else if (rd_strobe)
         rd_word <= silo_empty ? '0 : pack_word(1'b1, head_entry);
   end

   rx_silo_alarm #(.THRESH(ALARM_CNT)) u_alarm (
      .clk      (clk),
      .rst_n    (rst_n),
      .alarm_en (alarm_en),
      .load     (load),
      .rd       (rd_strobe),
      .alarm    (alarm)
   );

   // R4: done follows occupancy
   a_r4_done_after_load: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> rx_done);
   // R6: an empty read leaves the silo empty
   a_r6_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_strobe && !rx_done && !load |=> !rx_done && !rd_word[15]);
   // R5: a read with data yields a valid word
   a_r5_valid_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_strobe && rx_done |=> rd_word[15]);
   // R3: reserved word bits stay zero
   a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rd_word[11:10] == 2'b00);
endmodule

// File: tb/rx_silo_ctrl_tb.sv
module rx_silo_ctrl_tb;
   localparam int NL = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          scan_en = 1'b0;
   logic [NL-1:0] line_rx_en = '0;
   logic [NL-1:0] line_avail = '0;
   logic [NL*8-1:0] line_data = '0;
   logic [NL-1:0] line_par_err = '0, line_frm_err = '0, line_ovr_err = '0;
   logic          alarm_en = 1'b0;
   logic          rd_strobe = 1'b0;
   logic [NL-1:0] avail_clr;
   logic [15:0]   rd_word;
   logic          rx_done, alarm;

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   rx_silo_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .line_rx_en(line_rx_en),
      .line_avail(line_avail), .line_data(line_data),
      .line_par_err(line_par_err), .line_frm_err(line_frm_err),
      .line_ovr_err(line_ovr_err), .alarm_en(alarm_en), .rd_strobe(rd_strobe),
      .avail_clr(avail_clr), .rd_word(rd_word), .rx_done(rx_done), .alarm(alarm)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_word(input int ln, input logic [7:0] d,
                                            input logic [2:0] f);
      // f = {overrun, framing, parity}
      exp_word = {1'b1, f, 2'b00, 2'(ln), d};
   endfunction

   task automatic offer(input int ln, input logic [7:0] d, input logic [2:0] f);
      line_data[ln*8 +: 8] = d;
      line_ovr_err[ln] = f[2];
      line_frm_err[ln] = f[1];
      line_par_err[ln] = f[0];
      line_avail[ln] = 1'b1;
   endtask

   task automatic pump(input int maxc);
      for (int c = 0; c < maxc && line_avail != '0; c++) begin
         @(negedge clk);
         line_avail = line_avail & ~avail_clr;
      end
   endtask

   task automatic host_read(output logic [15:0] w);
      rd_strobe = 1'b1;
      @(negedge clk);
      rd_strobe = 1'b0;
      w = rd_word;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      finish_run();
   end

   initial begin
      logic [15:0] w;
      logic [3:0]  seen;
      repeat (3) @(negedge clk);
      // reset state
      chk(rd_word == 16'h0, "R6 reset word", rd_word, 0);
      chk(rx_done == 1'b0, "R4 reset done", rx_done, 0);
      chk(alarm == 1'b0, "R8 reset alarm", alarm, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(avail_clr == '0, "R2 idle clr", avail_clr, 0);

      // R1: scanner disabled
      line_rx_en = '1;
      offer(1, 8'h5A, 3'b000);
      pump(20);
      chk(line_avail[1] == 1'b1, "R1 scan off pending", line_avail, 4'h2);
      chk(rx_done == 1'b0, "R1 scan off done", rx_done, 0);
      scan_en = 1'b1;
      pump(20);
      chk(line_avail == '0, "R2 loaded after enable", line_avail, 0);
      chk(rx_done == 1'b1, "R4 done after load", rx_done, 1);
      host_read(w);
      chk(w == exp_word(1, 8'h5A, 3'b000), "R5 first read", w, exp_word(1, 8'h5A, 3'b000));
      chk(rx_done == 1'b0, "R4 done after drain", rx_done, 0);

      // R1: line disabled
      line_rx_en = 4'b1011;
      offer(2, 8'hC3, 3'b101);
      pump(20);
      chk(line_avail[2] == 1'b1, "R1 line off pending", line_avail, 4'h4);
      chk(rx_done == 1'b0, "R1 line off done", rx_done, 0);
      line_rx_en = '1;
      pump(20);
      host_read(w);
      chk(w == exp_word(2, 8'hC3, 3'b101), "R3 flags word", w, exp_word(2, 8'hC3, 3'b101));

      // R6: empty read
      host_read(w);
      chk(w == 16'h0, "R6 empty word", w, 0);
      chk(rx_done == 1'b0, "R6 empty stays", rx_done, 0);

      // R2/R3/R4/R5: sweep of lines, bytes and flag combinations
      for (int i = 0; i < 32; i++) begin
         logic [7:0] d = 8'((i * 37 + 5) & 255);
         offer(i % 4, d, 3'(i));
         pump(20);
         chk(rx_done == 1'b1, "R4 sweep done", rx_done, 1);
         host_read(w);
         chk(w == exp_word(i % 4, d, 3'(i)), "R3 sweep word", w, exp_word(i % 4, d, 3'(i)));
      end

      // R10: all lines at once
      for (int k = 0; k < NL; k++) offer(k, 8'(8'h40 + k), 3'b000);
      pump(30);
      chk(line_avail == '0, "R10 all loaded", line_avail, 0);
      seen = '0;
      for (int k = 0; k < NL; k++) begin
         host_read(w);
         chk(w[15:10] == 6'b100000 && w[7:0] == 8'h40 + w[9:8], "R10 tag", w, {8'h80 | w[9:8], 8'h40 + w[9:8]});
         seen[w[9:8]] = 1'b1;
      end
      chk(seen == 4'hF, "R10 each line once", seen, 4'hF);

      // R7: fill to 64, then blocked
      alarm_en = 1'b0;
      for (int i = 0; i < 64; i++) begin
         offer(i % 4, 8'(i), 3'b000);
         pump(20);
      end
      offer(1, 8'hAA, 3'b000);
      pump(20);
      chk(line_avail[1] == 1'b1, "R7 full pending", line_avail, 4'h2);
      host_read(w);
      chk(w == exp_word(0, 8'h00, 3'b000), "R7 oldest first", w, exp_word(0, 0, 0));
      pump(20);
      chk(line_avail == '0, "R7 loads after space", line_avail, 0);
      for (int i = 1; i < 64; i++) begin
         host_read(w);
         chk(w == exp_word(i % 4, 8'(i), 3'b000), "R5 order", w, exp_word(i % 4, 8'(i), 0));
      end
      host_read(w);
      chk(w == exp_word(1, 8'hAA, 3'b000), "R7 late char", w, exp_word(1, 8'hAA, 0));
      chk(rx_done == 1'b0, "R4 drained", rx_done, 0);

      // R8/R9: alarm
      alarm_en = 1'b1;
      for (int i = 0; i < 15; i++) begin
         offer(i % 4, 8'(i), 3'b000);
         pump(20);
      end
      chk(alarm == 1'b0, "R8 below threshold", alarm, 0);
      offer(3, 8'h0F, 3'b000);
      pump(20);
      chk(alarm == 1'b1, "R8 threshold reached", alarm, 1);
      host_read(w);
      chk(alarm == 1'b0, "R9 read clears", alarm, 0);
      for (int i = 0; i < 15; i++) begin
         offer(i % 4, 8'(i), 3'b000);
         pump(20);
      end
      chk(alarm == 1'b0, "R9 count restarted", alarm, 0);
      offer(2, 8'h77, 3'b000);
      pump(20);
      chk(alarm == 1'b1, "R8 second threshold", alarm, 1);
      alarm_en = 1'b0;
      @(negedge clk);
      chk(alarm == 1'b0, "R9 enable clears", alarm, 0);
      for (int i = 0; i < 31; i++) host_read(w);
      chk(rx_done == 1'b0, "R4 final empty", rx_done, 0);
      host_read(w);
      chk(w == 16'h0, "R6 final empty word", w, 0);

      finish_run();
   end
endmodule